// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source side of an interrupt controller. It holds the state of a fixed set of interrupt sources. Each source is fixed at build time either as a level source, whose input is a held level, or as a message source, whose input is a one-cycle trigger. Each source keeps a target server number, a priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. A priority of all ones (0xFF at the default width) masks the source.

When a source decides to present itself, it raises a per-source request. Requests leave the block one at a time on a valid/ready presentation port, which carries the server, the global source number and the priority. The global number is the local index plus a base offset. The presenter reports back with reject and end-of-interrupt (EOI) strobes that carry the global number. It can also request a resend, which makes every source re-evaluate whether to present again.

A level source is presented once for each assertion, and is not presented again until its sent flag is cleared by a reject or an EOI and a re-check then runs. A message source that is rejected is held until the next resend. A message source that is triggered while masked is remembered and replayed when a configuration write unmasks it.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset, every source has priority 0xFF, saved priority 0xFF, server 0 and all status flags clear, and `pres_valid` is low. The level or message type of each source comes from `LEVEL_MASK` (bit i set means source i is a level source) and reset does not change it.
- R2: A trigger on a message source whose priority is 0xFF sets masked-pending and presents nothing.
- R3: A trigger on a message source whose priority is not 0xFF presents that source. `pres_valid` is high in the cycle after the trigger.
- R4: A level source records its input in the asserted flag. When the input changes, a level check runs. The check presents the source and sets sent only if the priority is not 0xFF, asserted is set and sent is clear. As a result, a held input is presented only once.
- R5: A configuration write to index i (in range 0..NSRC-1) sets the server, priority and saved priority of source i. For a level source, the write then runs the level check.
- R6: A configuration write that gives a non-0xFF priority to a message source with masked-pending set clears masked-pending and presents the source.
- R7: A reject on a message source sets rejected, and the source is not presented again until a resend. A reject on a level source clears sent, and the source waits for a re-check before it is presented again.
- R8: An EOI clears sent on a level source. An EOI on a message source has no effect.
- R9: A resend runs the level check on every level source. For every message source with rejected set, the resend clears rejected and presents the source if its priority is not 0xFF.
- R10: The presented number is `BASE` plus the local index (0x1000 plus i by default). Reject and EOI numbers are translated back by removing `BASE`. Numbers outside `BASE`..`BASE+NSRC-1` are ignored.
- R11: Pending presentations are issued one per accepted transfer, lowest index first. While `pres_valid` is high and `pres_ready` is low, the presentation stays up, and the number shown can only fall.
- R12: A configuration write whose index is NSRC or above changes no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Per-source level (level sources) or one-cycle trigger (message sources) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | CIDX_W | Local source index of the write |
| cfg_srv | input | SRV_W | Server number to store |
| cfg_prio | input | PRIO_W | Priority to store, all ones masks the source |
| cfg_sav | input | PRIO_W | Saved priority to store |
| rej_vld | input | 1 | Reject strobe from presenter |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_vld | input | 1 | EOI strobe from presenter |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Request that all sources re-evaluate |
| pres_valid | output | 1 | A presentation is offered |
| pres_ready | input | 1 | Presenter accepts the offered presentation |
| pres_srv | output | SRV_W | Server of the offered source |
| pres_num | output | NUM_W | Global number of the offered source |
| pres_prio | output | PRIO_W | Priority of the offered source |

## Verification
The assertions rely on two assumptions. First, each cycle in which a message input is high counts as a separate trigger. Second, every input has a known value from the first clock edge on, with reset held low at the start. The bench drives every input to a defined value before reset is released. It changes inputs only at the falling edge and keeps message inputs high for one cycle at a time. The random phase sends reject and EOI numbers into a window that reaches just past both ends of the valid range. It also sends configuration indices up to twice the source count, so the ignore paths are exercised alongside normal traffic.

// File: rtl/isc_pkg.sv
package isc_pkg;
   typedef struct packed {
      logic asrt;
      logic sent;
      logic rej;
      logic mpend;
   } isc_stat_t;
endpackage

// File: rtl/isc_num_dec.sv
module isc_num_dec #(
   parameter int NSRC = 8,
   parameter int NUM_W = 16,
   parameter logic [NUM_W-1:0] BASE = 16'h1000
) (
   input  logic             vld,
   input  logic [NUM_W-1:0] num,
   output logic [NSRC-1:0]  hit
);
   // strip the base offset: one comparator per local source
   for (genvar i = 0; i < NSRC; i++) begin : g_cmp
      assign hit[i] = vld && (num == BASE + NUM_W'(i));
   end
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
   parameter int NSRC = 8,
   localparam int IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  req,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [NSRC-1:0]  oh
);
   // lowest index wins
   always_comb begin
      idx = '0;
      oh  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx   = IDX_W'(i);
            oh    = '0;
            oh[i] = 1'b1;
         end
      end
   end
   assign any = |req;
endmodule

// File: rtl/isc_src_slice.sv
module isc_src_slice
   import isc_pkg::*;
#(
   parameter int SRV_W = 4,
   parameter int PRIO_W = 8,
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_bit,
   input  logic              rej_hit,
   input  logic              eoi_hit,
   input  logic              cfg_hit,
   input  logic [SRV_W-1:0]  cfg_srv,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic [PRIO_W-1:0] cfg_sav,
   input  logic              resend,
   input  logic              grant,
   output logic              req,
   output logic [SRV_W-1:0]  srv,
   output logic [PRIO_W-1:0] prio,
   output logic [PRIO_W-1:0] sav,
   output isc_stat_t         stat
);
   localparam logic [PRIO_W-1:0] MASKED = '1;

   logic [SRV_W-1:0]  srv_q, srv_n;
   logic [PRIO_W-1:0] prio_q, prio_n, sav_q, sav_n;
   isc_stat_t         st_q, st_n;
   logic              req_q, fire;

   always_comb begin
      srv_n  = cfg_hit ? cfg_srv  : srv_q;
      prio_n = cfg_hit ? cfg_prio : prio_q;
      sav_n  = cfg_hit ? cfg_sav  : sav_q;
   end

   if (IS_LEVEL) begin : g_level
      logic recheck;
      always_comb begin
         st_n    = st_q;
         fire    = 1'b0;
         recheck = 1'b0;
         if (rej_hit) st_n.sent = 1'b0;
         if (eoi_hit) st_n.sent = 1'b0;
         if (in_bit != st_q.asrt) begin
            st_n.asrt = in_bit;
            recheck   = 1'b1;
         end
         if (cfg_hit) recheck = 1'b1;
         if (resend)  recheck = 1'b1;
         if (recheck && prio_n != MASKED && st_n.asrt && !st_n.sent) begin
            st_n.sent = 1'b1;
            fire      = 1'b1;
         end
      end
   end else begin : g_msg
      always_comb begin
         st_n = st_q;
         fire = 1'b0;
         if (rej_hit) st_n.rej = 1'b1;
         if (eoi_hit) st_n.sent = 1'b0;  // never set on a message source
         if (in_bit) begin
            if (prio_q == MASKED) st_n.mpend = 1'b1;
            else                  fire = 1'b1;
         end
         if (cfg_hit && st_n.mpend && cfg_prio != MASKED) begin
            st_n.mpend = 1'b0;
            fire       = 1'b1;
         end
         if (resend && st_n.rej) begin
            st_n.rej = 1'b0;
            if (prio_n != MASKED) fire = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_q  <= '0;
         prio_q <= MASKED;
         sav_q  <= MASKED;
         st_q   <= '0;
         req_q  <= 1'b0;
      end else begin
         srv_q  <= srv_n;
         prio_q <= prio_n;
         sav_q  <= sav_n;
         st_q   <= st_n;
         req_q  <= (req_q && !grant) || fire;
      end
   end

   assign req  = req_q;
   assign srv  = srv_q;
   assign prio = prio_q;
   assign sav  = sav_q;
   assign stat = st_q;
endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
   import isc_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int SRV_W = 4,
   parameter int PRIO_W = 8,
   parameter int NUM_W = 16,
   parameter logic [NUM_W-1:0] BASE = 16'h1000,
   parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
   localparam int IDX_W = $clog2(NSRC),
   localparam int CIDX_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic              cfg_we,
   input  logic [CIDX_W-1:0] cfg_idx,
   input  logic [SRV_W-1:0]  cfg_srv,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic [PRIO_W-1:0] cfg_sav,
   input  logic              rej_vld,
   input  logic [NUM_W-1:0]  rej_num,
   input  logic              eoi_vld,
   input  logic [NUM_W-1:0]  eoi_num,
   input  logic              resend_req,
   output logic              pres_valid,
   input  logic              pres_ready,
   output logic [SRV_W-1:0]  pres_srv,
   output logic [NUM_W-1:0]  pres_num,
   output logic [PRIO_W-1:0] pres_prio
);
   if (NSRC < 2) begin : g_bad_nsrc
      $error("isc_source_ctrl: NSRC must be at least 2");
   end
   if (PRIO_W < 2 || SRV_W < 1) begin : g_bad_width
      $error("isc_source_ctrl: PRIO_W must be >= 2 and SRV_W >= 1");
   end
   if (NUM_W > 31 || (int'(BASE) + NSRC) > (1 << NUM_W)) begin : g_bad_base
      $error("isc_source_ctrl: BASE + NSRC does not fit in NUM_W");
   end

   logic [NSRC-1:0]   cfg_hit, rej_hit, eoi_hit, req_v, oh, grant;
   logic [SRV_W-1:0]  srv_a  [NSRC];
   logic [PRIO_W-1:0] prio_a [NSRC];
   logic [PRIO_W-1:0] sav_a  [NSRC];
   isc_stat_t         stat_a [NSRC];
   logic [IDX_W-1:0]  win_idx;
   logic              any_req;

   // flattened state seen by the bound checker
   logic [NSRC*PRIO_W-1:0] prio_flat, sav_flat;
   logic [NSRC-1:0]        asrt_v, sent_v, rej_v, pend_v;

   isc_num_dec #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) u_rej_dec (
      .vld(rej_vld), .num(rej_num), .hit(rej_hit));
   isc_num_dec #(.NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE)) u_eoi_dec (
      .vld(eoi_vld), .num(eoi_num), .hit(eoi_hit));

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign cfg_hit[i] = cfg_we && (cfg_idx == CIDX_W'(i));

      isc_src_slice #(.SRV_W(SRV_W), .PRIO_W(PRIO_W), .IS_LEVEL(LEVEL_MASK[i])) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_bit  (src_in[i]),
         .rej_hit (rej_hit[i]),
         .eoi_hit (eoi_hit[i]),
         .cfg_hit (cfg_hit[i]),
         .cfg_srv (cfg_srv),
         .cfg_prio(cfg_prio),
         .cfg_sav (cfg_sav),
         .resend  (resend_req),
         .grant   (grant[i]),
         .req     (req_v[i]),
         .srv     (srv_a[i]),
         .prio    (prio_a[i]),
         .sav     (sav_a[i]),
         .stat    (stat_a[i])
      );

      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_a[i];
      assign sav_flat[i*PRIO_W +: PRIO_W]  = sav_a[i];
      assign asrt_v[i] = stat_a[i].asrt;
      assign sent_v[i] = stat_a[i].sent;
      assign rej_v[i]  = stat_a[i].rej;
      assign pend_v[i] = stat_a[i].mpend;
   end

   isc_pick #(.NSRC(NSRC)) u_pick (
      .req(req_v), .any(any_req), .idx(win_idx), .oh(oh));

   assign grant      = oh & {NSRC{pres_ready}};
   assign pres_valid = any_req;
   assign pres_num   = BASE + NUM_W'(win_idx);
   assign pres_srv   = srv_a[win_idx];
   assign pres_prio  = prio_a[win_idx];
endmodule

// File: rtl/isc_source_ctrl_chk.sv
module isc_source_ctrl_chk #(
   parameter int NSRC = 8,
   parameter int PRIO_W = 8,
   parameter int NUM_W = 16,
   parameter logic [NUM_W-1:0] BASE = 16'h1000,
   parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
   localparam int CIDX_W = $clog2(NSRC) + 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NSRC-1:0]        src_in,
   input logic                   cfg_we,
   input logic [CIDX_W-1:0]      cfg_idx,
   input logic [PRIO_W-1:0]      cfg_sav,
   input logic                   rej_vld,
   input logic                   pres_valid,
   input logic                   pres_ready,
   input logic [NUM_W-1:0]       pres_num,
   input logic [NSRC*PRIO_W-1:0] prio_flat,
   input logic [NSRC*PRIO_W-1:0] sav_flat,
   input logic [NSRC-1:0]        asrt_v,
   input logic [NSRC-1:0]        sent_v,
   input logic [NSRC-1:0]        rej_v,
   input logic [NSRC-1:0]        pend_v
);
   localparam logic [PRIO_W-1:0] MASKED = '1;

   a_r10_num_range: assert property (@(posedge clk) disable iff (!rst_n)
      pres_valid |-> (pres_num >= BASE && pres_num < BASE + NUM_W'(NSRC)));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pres_valid && !pres_ready) |=> (pres_valid && pres_num <= $past(pres_num)));

   a_r12_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_idx) >= NSRC) |=>
         (prio_flat == $past(prio_flat) && sav_flat == $past(sav_flat)));

   for (genvar i = 0; i < NSRC; i++) begin : g_per
      a_r5_saved_written: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_idx == CIDX_W'(i)) |=> (sav_flat[i*PRIO_W +: PRIO_W] == $past(cfg_sav)));

      a_r7_rej_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rej_v[i]) |-> $past(rej_vld));

      if (LEVEL_MASK[i]) begin : g_lvl
         a_r4_sent_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sent_v[i]) |-> (asrt_v[i] && prio_flat[i*PRIO_W +: PRIO_W] != MASKED));
      end else begin : g_msg
         a_r2_pend_masked: assert property (@(posedge clk) disable iff (!rst_n)
            pend_v[i] |-> (prio_flat[i*PRIO_W +: PRIO_W] == MASKED));

         a_r3_fire: assert property (@(posedge clk) disable iff (!rst_n)
            (src_in[i] && prio_flat[i*PRIO_W +: PRIO_W] != MASKED) |=> pres_valid);
      end
   end
endmodule

bind isc_source_ctrl isc_source_ctrl_chk #(
   .NSRC(NSRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_in    (src_in),
   .cfg_we    (cfg_we),
   .cfg_idx   (cfg_idx),
   .cfg_sav   (cfg_sav),
   .rej_vld   (rej_vld),
   .pres_valid(pres_valid),
   .pres_ready(pres_ready),
   .pres_num  (pres_num),
   .prio_flat (prio_flat),
   .sav_flat  (sav_flat),
   .asrt_v    (asrt_v),
   .sent_v    (sent_v),
   .rej_v     (rej_v),
   .pend_v    (pend_v)
);

// File: tb/isc_source_ctrl_tb.sv
module isc_source_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 8;
   localparam logic [7:0] LVL = 8'hF0;
   localparam logic [15:0] BASE = 16'h1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]  src_in = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [3:0]  cfg_srv = '0;
   logic [7:0]  cfg_prio = '0;
   logic [7:0]  cfg_sav = '0;
   logic        rej_vld = 1'b0;
   logic [15:0] rej_num = '0;
   logic        eoi_vld = 1'b0;
   logic [15:0] eoi_num = '0;
   logic        resend_req = 1'b0;
   logic        pres_ready = 1'b0;
   logic        pres_valid;
   logic [3:0]  pres_srv;
   logic [15:0] pres_num;
   logic [7:0]  pres_prio;

   int checks = 0;
   int errors = 0;

   // bench-side expected state
   bit [3:0] m_srv [NSRC];
   bit [7:0] m_prio [NSRC];
   bit m_ast [NSRC];
   bit m_sent [NSRC];
   bit m_rej [NSRC];
   bit m_mp [NSRC];
   bit m_req [NSRC];

   always #(CLK_PERIOD/2) clk = ~clk;

   isc_source_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_srv(cfg_srv),
      .cfg_prio(cfg_prio), .cfg_sav(cfg_sav),
      .rej_vld(rej_vld), .rej_num(rej_num),
      .eoi_vld(eoi_vld), .eoi_num(eoi_num),
      .resend_req(resend_req),
      .pres_valid(pres_valid), .pres_ready(pres_ready),
      .pres_srv(pres_srv), .pres_num(pres_num), .pres_prio(pres_prio));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_low();
      for (int i = 0; i < NSRC; i++) if (m_req[i]) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NSRC; i++) begin
         m_srv[i] = '0; m_prio[i] = 8'hFF; m_ast[i] = 0; m_sent[i] = 0;
         m_rej[i] = 0; m_mp[i] = 0; m_req[i] = 0;
      end
   endtask

   task automatic model_next();
      int w;
      w = m_low();
      for (int i = 0; i < NSRC; i++) begin
         bit lvl, fire, rchk, grant;
         lvl = LVL[i]; fire = 0; rchk = 0;
         grant = pres_ready && (w == i);
         if (rej_vld && rej_num == BASE + 16'(i)) begin
            if (lvl) m_sent[i] = 0; else m_rej[i] = 1;
         end
         if (eoi_vld && eoi_num == BASE + 16'(i) && lvl) m_sent[i] = 0;
         if (lvl) begin
            if (src_in[i] != m_ast[i]) begin m_ast[i] = src_in[i]; rchk = 1; end
         end else if (src_in[i]) begin
            if (m_prio[i] == 8'hFF) m_mp[i] = 1; else fire = 1;
         end
         if (cfg_we && int'(cfg_idx) == i) begin
            m_srv[i] = cfg_srv; m_prio[i] = cfg_prio;
            if (lvl) rchk = 1;
            else if (m_mp[i] && cfg_prio != 8'hFF) begin m_mp[i] = 0; fire = 1; end
         end
         if (resend_req) begin
            if (lvl) rchk = 1;
            else if (m_rej[i]) begin
               m_rej[i] = 0;
               if (m_prio[i] != 8'hFF) fire = 1;
            end
         end
         if (lvl && rchk && m_prio[i] != 8'hFF && m_ast[i] && !m_sent[i]) begin
            m_sent[i] = 1; fire = 1;
         end
         m_req[i] = (m_req[i] && !grant) || fire;
      end
   endtask

   task automatic compare(input string tag);
      int w;
      w = m_low();
      chk(pres_valid == (w >= 0), {tag, " valid"}, pres_valid, (w >= 0));
      if (w >= 0 && pres_valid) begin
         chk(pres_num == BASE + 16'(w), {tag, " num"}, pres_num, BASE + 16'(w));
         chk(pres_srv == m_srv[w] && pres_prio == m_prio[w], {tag, " srv/prio"},
             {pres_srv, pres_prio}, {m_srv[w], m_prio[w]});
      end
   endtask

   // inputs set before the call are seen at the next rising edge
   task automatic step();
      model_next();
      @(posedge clk);
      @(negedge clk);
      compare("R11 model");
      src_in = src_in & LVL;
      cfg_we = 0; rej_vld = 0; eoi_vld = 0; resend_req = 0;
   endtask

   task automatic cfg(input int idx, input int srv, input int prio);
      cfg_we = 1; cfg_idx = 4'(idx); cfg_srv = 4'(srv); cfg_prio = 8'(prio); cfg_sav = 8'(prio ^ 8'h3C);
      step();
   endtask

   task automatic pop();
      pres_ready = 1; step(); pres_ready = 0;
   endtask

   task automatic expect_none(input string tag);
      chk(pres_valid == 1'b0, tag, pres_valid, 0);
   endtask

   task automatic expect_pres(input int num, input int srv, input int prio, input string tag);
      chk(pres_valid == 1'b1, tag, pres_valid, 1);
      chk(pres_num == 16'(num), tag, pres_num, num);
      chk(pres_srv == 4'(srv) && pres_prio == 8'(prio), tag, {pres_srv, pres_prio}, {4'(srv), 8'(prio)});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      expect_none("R1 reset valid");
      // R1/R2: masked after reset, trigger only sets pending
      src_in[0] = 1; step(); expect_none("R2 masked trigger");
      cfg(0, 3, 5); expect_pres(16'h1000, 3, 5, "R6 unmask replays");
      pop(); expect_none("R11 popped");
      src_in[0] = 1; step(); expect_pres(16'h1000, 3, 5, "R3 unmasked trigger");
      pop();
      // R7/R9 message reject and resend
      rej_vld = 1; rej_num = 16'h1000; step(); expect_none("R7 msg rejected held");
      resend_req = 1; step(); expect_pres(16'h1000, 3, 5, "R9 resend replays");
      pop();
      rej_vld = 1; rej_num = 16'h1000; step();
      cfg(0, 3, 8'hFF);
      resend_req = 1; step(); expect_none("R9 masked rejected not presented");
      cfg(0, 3, 5); expect_none("R9 rejected cleared not pending");
      // level source
      cfg(4, 1, 2); expect_none("R5 level low no present");
      src_in[4] = 1; step(); expect_pres(16'h1004, 1, 2, "R4 level rise");
      pop();
      repeat (3) step();
      expect_none("R4 held level once");
      resend_req = 1; step(); expect_none("R4 sent blocks resend");
      eoi_vld = 1; eoi_num = 16'h1004; step(); expect_none("R8 eoi waits for recheck");
      resend_req = 1; step(); expect_pres(16'h1004, 1, 2, "R8 eoi then resend");
      pop();
      rej_vld = 1; rej_num = 16'h1004; step(); expect_none("R7 level reject waits");
      resend_req = 1; step(); expect_pres(16'h1004, 1, 2, "R7 level reject then resend");
      pop();
      src_in[4] = 0; step();
      eoi_vld = 1; eoi_num = 16'h1004; step();
      resend_req = 1; step(); expect_none("R4 level low after eoi");
      // R5: masked level, then config write
      src_in[5] = 1; step(); expect_none("R5 masked level");
      cfg(5, 2, 4); expect_pres(16'h1005, 2, 4, "R5 cfg runs level check");
      pop();
      eoi_vld = 1; eoi_num = 16'h1001; step(); expect_none("R8 msg eoi no effect");
      // R10 out-of-range numbers
      rej_vld = 1; rej_num = 16'h0FFF; step();
      rej_vld = 1; rej_num = 16'h1008; step();
      resend_req = 1; step(); expect_none("R10 out-of-range ignored");
      // R11 ordering
      cfg(1, 4, 7);
      cfg(3, 5, 6);
      src_in[3] = 1; src_in[1] = 1; step(); expect_pres(16'h1001, 4, 7, "R11 lowest first");
      step(); expect_pres(16'h1001, 4, 7, "R11 hold without ready");
      pop(); expect_pres(16'h1003, 5, 6, "R11 next in order");
      pop(); expect_none("R11 drained");
      // R12 out-of-range config
      cfg(0, 3, 8'hFF);
      cfg(8, 9, 1);
      src_in[0] = 1; step(); expect_none("R12 oob config ignored");
      cfg(0, 3, 5); expect_pres(16'h1000, 3, 5, "R6 pending replay");
      pop();
      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom % 8 == 0) begin
            cfg_we = 1; cfg_idx = 4'($urandom % 16); cfg_srv = 4'($urandom);
            cfg_prio = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 16);
            cfg_sav = 8'($urandom);
         end
         if ($urandom % 8 == 0) begin rej_vld = 1; rej_num = BASE - 16'd1 + 16'($urandom % (NSRC + 2)); end
         if ($urandom % 8 == 0) begin eoi_vld = 1; eoi_num = BASE - 16'd1 + 16'($urandom % (NSRC + 2)); end
         if ($urandom % 16 == 0) resend_req = 1;
         for (int i = 0; i < NSRC; i++) begin
            if (LVL[i]) begin
               if ($urandom % 16 == 0) src_in[i] = ~src_in[i];
            end else if ($urandom % 8 == 0) src_in[i] = 1;
         end
         pres_ready = ($urandom % 2) == 1;
         step();
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule